// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a small set of ownership flags that two independent ports, left and right, share. Each flag guards one shared resource. A port claims a flag by writing a data value whose bit 0 is 0. It learns whether it holds the flag by reading it back, and it hands the flag back by writing a value whose bit 0 is 1. The block is a single-clock synchronous model. Writes are captured on the rising clock edge. Read data is combinational from the current flag state.

Each flag is a small state machine with five named states:
- `FLAG_FREE`: nobody holds the flag.
- `FLAG_HELD_L`: the left port holds the flag.
- `FLAG_HELD_R`: the right port holds the flag.
- `FLAG_HELD_L_WANT_R`: the left port holds the flag and the right port is waiting for it.
- `FLAG_HELD_R_WANT_L`: the right port holds the flag and the left port is waiting for it.

The transitions are:
- **claim**: FREE to HELD_L or HELD_R.
- **dual claim**: FREE to HELD_L_WANT_R. The left port wins.
- **queue**: HELD_x to HELD_x_WANT_y.
- **release**: HELD_x to FREE.
- **hand-over**: HELD_x_WANT_y to HELD_y, or HELD_x to HELD_y when the other port asks in the same cycle as the release.

Top module: `sema_unit`

## Requirements
- R1: After reset every flag is in FLAG_FREE with no waiting request, so reads of any flag from either port return all ones.
- R2: While a port's `sel_n` is high, its write strobe and data have no effect on any flag.
- R3: The index input selects one of eight flags (index 0 to 7). A write changes only the flag it selects.
- R4: Only bit 0 of the write data is decoded. Bit 0 = 0 means claim and bit 0 = 1 means release. All other bits are ignored.
- R5: A claim of a free flag grants it at the write edge. From the next cycle, reads of that flag return all zeros to the owner and all ones to the other port.
- R6: A release by the owner frees the flag at the write edge.
- R7: A release written by a port that does not own the flag leaves the flag unchanged.
- R8: A claim of a flag held by the other port is queued. The waiting port is granted the flag at the edge where the owner releases it.
- R9: When both ports claim the same free flag at the same edge, the left port is granted and the right port's claim is queued.
- R10: While `sel_n` is high, that port's read data is all ones.
- R11: If the owner releases a flag at the same edge where the other port claims it, the other port is granted the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel_n | input | 1 | Left port semaphore select, active low |
| l_idx | input | 3 | Left port flag index |
| l_we | input | 1 | Left port write strobe |
| l_wdata | input | 8 | Left port write data; only bit 0 is used |
| l_rdata | output | 8 | Left port read data: all zeros if left owns the flag, otherwise all ones |
| r_sel_n | input | 1 | Right port semaphore select, active low |
| r_idx | input | 3 | Right port flag index |
| r_we | input | 1 | Right port write strobe |
| r_wdata | input | 8 | Right port write data; only bit 0 is used |
| r_rdata | output | 8 | Right port read data: all zeros if right owns the flag, otherwise all ones |

## Verification
Two situations are hard to reach from the ports:
- A queued claim meeting a release by the owner.
- A release landing at the same edge as a claim from the other port.

Both need writes from the two ports placed on exactly the same clock edge. The bench has a task that drives both ports in one half-cycle, so it can build the dual claim, the queue-then-release sequence, and the simultaneous release-and-claim on purpose. After each of these it reads the flag back from both ports to see who holds it.

// File: rtl/sema_pkg.sv
package sema_pkg;

    typedef enum logic [2:0] {
        FLAG_FREE          = 3'd0,
        FLAG_HELD_L        = 3'd1,
        FLAG_HELD_R        = 3'd2,
        FLAG_HELD_L_WANT_R = 3'd3,
        FLAG_HELD_R_WANT_L = 3'd4
    } flag_st_e;

endpackage

// File: rtl/sema_port_dec.sv
module sema_port_dec #(
    parameter int NFLAG = 8,
    localparam int IW = $clog2(NFLAG)
) (
    input  logic             sel_n,
    input  logic [IW-1:0]    idx,
    input  logic             we,
    input  logic             wbit,
    output logic [NFLAG-1:0] req_vec,
    output logic [NFLAG-1:0] rel_vec
);

    always_comb begin
        req_vec = '0;
        rel_vec = '0;
        if (!sel_n && we) begin
            if (wbit) rel_vec[idx] = 1'b1;
            else      req_vec[idx] = 1'b1;
        end
    end

endmodule

// File: rtl/sema_flag_fsm.sv
module sema_flag_fsm
    import sema_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_l,
    input  logic     rel_l,
    input  logic     req_r,
    input  logic     rel_r,
    output flag_st_e st,
    output logic     own_l,
    output logic     own_r
);

    flag_st_e st_q, st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLAG_FREE;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLAG_FREE: begin
                if (req_l)      st_d = req_r ? FLAG_HELD_L_WANT_R : FLAG_HELD_L;
                else if (req_r) st_d = FLAG_HELD_R;
            end
            FLAG_HELD_L: begin
                if (rel_l)      st_d = req_r ? FLAG_HELD_R : FLAG_FREE;
                else if (req_r) st_d = FLAG_HELD_L_WANT_R;
            end
            FLAG_HELD_L_WANT_R: begin
                if (rel_l)      st_d = FLAG_HELD_R;
            end
            FLAG_HELD_R: begin
                if (rel_r)      st_d = req_l ? FLAG_HELD_L : FLAG_FREE;
                else if (req_l) st_d = FLAG_HELD_R_WANT_L;
            end
            FLAG_HELD_R_WANT_L: begin
                if (rel_r)      st_d = FLAG_HELD_L;
            end
            default:            st_d = FLAG_FREE;
        endcase
    end

    // Outputs
    always_comb begin
        st    = st_q;
        own_l = (st_q == FLAG_HELD_L) || (st_q == FLAG_HELD_L_WANT_R);
        own_r = (st_q == FLAG_HELD_R) || (st_q == FLAG_HELD_R_WANT_L);
    end

endmodule

// File: rtl/sema_read_view.sv
module sema_read_view #(
    parameter int NFLAG = 8,
    parameter int DW    = 8,
    localparam int IW   = $clog2(NFLAG)
) (
    input  logic             sel_n,
    input  logic [IW-1:0]    idx,
    input  logic [NFLAG-1:0] own_vec,
    output logic [DW-1:0]    rdata
);

    always_comb begin
        if (!sel_n && own_vec[idx]) rdata = '0;
        else                        rdata = '1;
    end

endmodule

// File: rtl/sema_unit.sv
module sema_unit
    import sema_pkg::*;
#(
    parameter int NFLAG = 8,
    parameter int DW    = 8,
    localparam int IW   = $clog2(NFLAG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_sel_n,
    input  logic [IW-1:0] l_idx,
    input  logic          l_we,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    input  logic          r_sel_n,
    input  logic [IW-1:0] r_idx,
    input  logic          r_we,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata
);

    logic [NFLAG-1:0] req_l_vec, rel_l_vec, req_r_vec, rel_r_vec;
    logic [NFLAG-1:0] own_l_vec, own_r_vec;
    flag_st_e [NFLAG-1:0] st_vec;

    sema_port_dec #(.NFLAG(NFLAG)) u_dec_l (
        .sel_n(l_sel_n), .idx(l_idx), .we(l_we), .wbit(l_wdata[0]),
        .req_vec(req_l_vec), .rel_vec(rel_l_vec)
    );

    sema_port_dec #(.NFLAG(NFLAG)) u_dec_r (
        .sel_n(r_sel_n), .idx(r_idx), .we(r_we), .wbit(r_wdata[0]),
        .req_vec(req_r_vec), .rel_vec(rel_r_vec)
    );

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        sema_flag_fsm u_fsm (
            .clk(clk), .rst_n(rst_n),
            .req_l(req_l_vec[i]), .rel_l(rel_l_vec[i]),
            .req_r(req_r_vec[i]), .rel_r(rel_r_vec[i]),
            .st(st_vec[i]), .own_l(own_l_vec[i]), .own_r(own_r_vec[i])
        );
    end

    sema_read_view #(.NFLAG(NFLAG), .DW(DW)) u_view_l (
        .sel_n(l_sel_n), .idx(l_idx), .own_vec(own_l_vec), .rdata(l_rdata)
    );

    sema_read_view #(.NFLAG(NFLAG), .DW(DW)) u_view_r (
        .sel_n(r_sel_n), .idx(r_idx), .own_vec(own_r_vec), .rdata(r_rdata)
    );

endmodule

// File: rtl/sema_unit_chk.sv
module sema_unit_chk
    import sema_pkg::*;
#(
    parameter int NFLAG = 8,
    parameter int DW    = 8,
    localparam int IW   = $clog2(NFLAG)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 l_sel_n,
    input logic [IW-1:0]        l_idx,
    input logic                 l_we,
    input logic [DW-1:0]        l_wdata,
    input logic [DW-1:0]        l_rdata,
    input logic                 r_sel_n,
    input logic [IW-1:0]        r_idx,
    input logic                 r_we,
    input logic [DW-1:0]        r_wdata,
    input flag_st_e [NFLAG-1:0] st_vec
);

    logic l_claim, r_claim, l_drop, r_drop;
    assign l_claim = !l_sel_n && l_we && !l_wdata[0];
    assign r_claim = !r_sel_n && r_we && !r_wdata[0];
    assign l_drop  = !l_sel_n && l_we &&  l_wdata[0];
    assign r_drop  = !r_sel_n && r_we &&  r_wdata[0];

    // R2: with both ports deselected no flag moves
    a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel_n && r_sel_n) |=> $stable(st_vec));

    // R5: the left owner sees all zeros on readback
    a_r5_owner_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_sel_n && (st_vec[l_idx] == FLAG_HELD_L)) |-> (l_rdata == '0));

    // R7: a right release of a left-held flag changes nothing
    a_r7_foreign_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (r_drop && l_sel_n && (st_vec[r_idx] == FLAG_HELD_L))
        |=> (st_vec[$past(r_idx)] == FLAG_HELD_L));

    // R8: a queued right claim takes over when left releases
    a_r8_handover: assert property (@(posedge clk) disable iff (!rst_n)
        (l_drop && r_sel_n && (st_vec[l_idx] == FLAG_HELD_L_WANT_R))
        |=> (st_vec[$past(l_idx)] == FLAG_HELD_R));

    // R9: a dual claim of a free flag goes to the left port
    a_r9_left_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (l_claim && r_claim && (l_idx == r_idx) && (st_vec[l_idx] == FLAG_FREE))
        |=> (st_vec[$past(l_idx)] == FLAG_HELD_L_WANT_R));

endmodule

bind sema_unit sema_unit_chk #(.NFLAG(NFLAG), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_idx(l_idx), .l_we(l_we), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel_n(r_sel_n), .r_idx(r_idx), .r_we(r_we), .r_wdata(r_wdata),
    .st_vec(st_vec)
);

// File: tb/tb_sema_unit.sv
module tb_sema_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NFLAG = 8;
    localparam int DW = 8;
    localparam logic [DW-1:0] ONES = '1;
    localparam logic [DW-1:0] ZERO = '0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_sel_n = 1'b1, r_sel_n = 1'b1;
    logic [2:0] l_idx = '0, r_idx = '0;
    logic l_we = 1'b0, r_we = 1'b0;
    logic [DW-1:0] l_wdata = '1, r_wdata = '1;
    logic [DW-1:0] l_rdata, r_rdata;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sema_unit #(.NFLAG(NFLAG), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .l_sel_n(l_sel_n), .l_idx(l_idx), .l_we(l_we), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel_n(r_sel_n), .r_idx(r_idx), .r_we(r_we), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_ports();
        l_sel_n = 1'b1; r_sel_n = 1'b1; l_we = 1'b0; r_we = 1'b0;
        l_wdata = '1; r_wdata = '1;
    endtask

    // One write per port on the same edge; use_l/use_r select which ports act
    task automatic wr2(input bit use_l, input logic [2:0] li, input logic [DW-1:0] ld,
                       input bit use_r, input logic [2:0] ri, input logic [DW-1:0] rd);
        @(negedge clk);
        l_sel_n = !use_l; l_we = use_l; l_idx = li; l_wdata = ld;
        r_sel_n = !use_r; r_we = use_r; r_idx = ri; r_wdata = rd;
        @(posedge clk);
        @(negedge clk);
        idle_ports();
    endtask

    task automatic wr_l(input logic [2:0] i, input logic [DW-1:0] d);
        wr2(1'b1, i, d, 1'b0, 3'd0, ONES);
    endtask

    task automatic wr_r(input logic [2:0] i, input logic [DW-1:0] d);
        wr2(1'b0, 3'd0, ONES, 1'b1, i, d);
    endtask

    // Read one flag from both ports in the low clock phase
    task automatic rd_both(input string req, input logic [2:0] i,
                           input logic [DW-1:0] exp_l, input logic [DW-1:0] exp_r);
        @(negedge clk);
        l_sel_n = 1'b0; l_we = 1'b0; l_idx = i;
        r_sel_n = 1'b0; r_we = 1'b0; r_idx = i;
        #1;
        check({req, " left"}, l_rdata, exp_l);
        check({req, " right"}, r_rdata, exp_r);
        idle_ports();
    endtask

    task automatic t_reset();
        for (int i = 0; i < NFLAG; i++) rd_both("R1", 3'(i), ONES, ONES);
    endtask

    task automatic t_claim_index();
        wr_l(3'd3, ZERO);
        rd_both("R5", 3'd3, ZERO, ONES);
        rd_both("R3", 3'd2, ONES, ONES);
        rd_both("R3", 3'd4, ONES, ONES);
    endtask

    task automatic t_release();
        wr_l(3'd3, ONES);
        rd_both("R6", 3'd3, ONES, ONES);
        wr_r(3'd3, ZERO);
        rd_both("R6", 3'd3, ONES, ZERO);
        wr_r(3'd3, ONES);
        rd_both("R6", 3'd3, ONES, ONES);
    endtask

    task automatic t_data_bit0();
        wr_l(3'd5, 8'hFE);
        rd_both("R4", 3'd5, ZERO, ONES);
        wr_l(3'd5, 8'h01);
        rd_both("R4", 3'd5, ONES, ONES);
    endtask

    task automatic t_foreign_release();
        wr_l(3'd1, ZERO);
        wr_r(3'd1, ONES);
        rd_both("R7", 3'd1, ZERO, ONES);
    endtask

    task automatic t_desel();
        // R10: left owns flag 1, but with sel_n high its read data is all ones
        @(negedge clk);
        l_idx = 3'd1; l_sel_n = 1'b1;
        #1;
        check("R10 left", l_rdata, ONES);
        // R2: deselected claim on flag 0 and release on flag 1 do nothing
        @(negedge clk);
        l_sel_n = 1'b1; l_we = 1'b1; l_idx = 3'd0; l_wdata = ZERO;
        r_sel_n = 1'b1; r_we = 1'b1; r_idx = 3'd0; r_wdata = ZERO;
        @(posedge clk);
        @(negedge clk);
        l_idx = 3'd1; l_wdata = ONES;
        @(posedge clk);
        @(negedge clk);
        idle_ports();
        rd_both("R2", 3'd0, ONES, ONES);
        rd_both("R2", 3'd1, ZERO, ONES);
        wr_l(3'd1, ONES);
    endtask

    task automatic t_queue();
        wr_l(3'd4, ZERO);
        wr_r(3'd4, ZERO);
        rd_both("R8 queued", 3'd4, ZERO, ONES);
        wr_l(3'd4, ONES);
        rd_both("R8 granted", 3'd4, ONES, ZERO);
        wr_r(3'd4, ONES);
    endtask

    task automatic t_dual_claim();
        wr2(1'b1, 3'd6, ZERO, 1'b1, 3'd6, ZERO);
        rd_both("R9 left wins", 3'd6, ZERO, ONES);
        wr_l(3'd6, ONES);
        rd_both("R9 right queued", 3'd6, ONES, ZERO);
        wr_r(3'd6, ONES);
    endtask

    task automatic t_same_edge_handover();
        wr_l(3'd7, ZERO);
        wr2(1'b1, 3'd7, ONES, 1'b1, 3'd7, ZERO);
        rd_both("R11", 3'd7, ONES, ZERO);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_claim_index();
        t_release();
        t_data_bit0();
        t_foreign_release();
        t_desel();
        t_queue();
        t_dual_claim();
        t_same_edge_handover();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule